// File: doc/BRIEF.md
# Duel-Based Fault Isolation Score Tracker

This block narrows down which single cell of a small reconfigurable resource grid holds a stuck-at fault. Competing configurations are split into a left-half group and a right-half group. Each test round runs one configuration from each group side by side and compares their outputs. For every round the block is given two usage maps, one bit per grid cell, and a flag that says whether the pair disagreed. It keeps a score for each cell. On a disagreement it raises the score of every cell that either configuration used. On an agreement it permanently clears those cells as innocent.

After each round the block walks the grid one cell per clock. The suspects are the cells that have not been cleared and whose score equals the highest score among such cells. At the end of the walk the block publishes how many suspects there are. When exactly one suspect is left, it also gives that cell's row and column. If the suspect count stops falling over several rounds, the block raises a stall flag. That flag asks the surrounding system to swap half of the used columns with unused ones. The system acknowledges once it has done so.

Top module: `duel_isolator`

## Requirements
- R1: After reset the outputs are: suspect_count equals ROWS*COLS, stall is 0, isolated is 0, busy is 0, done is 0, and fault_row and fault_col are 0. Every cell starts with a score of 0 and not cleared.
- R2: When duel_valid is sampled high while busy is 0, the maps and the mismatch flag are captured at that edge. busy is then high for exactly ROWS*COLS cycles. done is a one-cycle pulse that rises ROWS*COLS edges after the capturing edge, in the same cycle that busy falls. A duel_valid that arrives while busy is 1 is ignored.
- R3: When mismatch is 1, every cell not yet cleared whose bit is set in left_map OR right_map has its score raised by 1. The bit for a cell is row*COLS+col. Scores are 6 bits wide and stop at 63.
- R4: When mismatch is 0, every cell set in either map is cleared for good. A cleared cell is never a suspect again, even if a later mismatching duel uses it.
- R5: suspect_count is the number of cells that are not cleared and whose score equals the largest score among cells that are not cleared. It is 0 when every cell is cleared. It changes only in the cycle that done is high.
- R6: isolated is 1 exactly when suspect_count is 1. fault_row and fault_col then give that cell's row and column. Both read 0 while isolated is 0.
- R7: A run counter is updated at the end of each scan. It goes up by 1, stopping at 3, when the new count is not lower than the previous count and is greater than 1. Otherwise it returns to 0. stall is high while the counter equals 3.
- R8: halve_ack clears the run counter, so stall is 0 from the following cycle. An acknowledge takes priority over a scan that finishes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duel_valid | input | 1 | Starts a scan for the presented duel |
| left_map | input | ROWS*COLS | Cells used by the left-half configuration |
| right_map | input | ROWS*COLS | Cells used by the right-half configuration |
| mismatch | input | 1 | 1 when the pair's outputs disagreed |
| halve_ack | input | 1 | Column halving has been carried out |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| suspect_count | output | clog2(ROWS*COLS+1) | Number of current suspects |
| stall | output | 1 | Request for a column-halving step |
| isolated | output | 1 | Exactly one suspect remains |
| fault_row | output | clog2(ROWS) | Row of the single suspect |
| fault_col | output | clog2(COLS) | Column of the single suspect |

## Verification
A corrupted cell score or cleared flag stays hidden inside the grid until the next scan passes over that cell. It then shows up, at the done pulse of that round, as a wrong suspect_count or a wrong pair of coordinates. The detection delay is therefore at most one duel plus ROWS*COLS cycles. A damaged scan index or controller shows up at once as done arriving at the wrong cycle. A faulty run counter shows up as a stall flag that rises in the wrong round, or that stays high after halve_ack.

// File: rtl/duel_pkg.sv
package duel_pkg;

    // Width of each cell's score counter.
    localparam int unsigned SCORE_W = 6;

    typedef logic [SCORE_W-1:0] score_t;

    // State held for one grid cell.
    typedef struct packed {
        logic   cleared;
        score_t score;
    } cell_t;

    // Adds one to a score and holds it at the top value.
    function automatic score_t score_bump(input score_t v);
        return (v == '1) ? v : score_t'(v + 1'b1);
    endfunction

endpackage

// File: rtl/duel_cell_rule.sv
module duel_cell_rule
    import duel_pkg::*;
(
    input  cell_t cur,
    input  logic  used,
    input  logic  mismatch,
    output cell_t nxt
);

    always_comb begin
        nxt = cur;
        if (used && !cur.cleared) begin
            if (mismatch) nxt.score   = score_bump(cur.score);
            else          nxt.cleared = 1'b1;
        end
    end

    // R4: a cleared cell is never changed again
    always_comb begin
        if (cur.cleared) a_r4_cleared_frozen: assert (nxt == cur);
    end

endmodule

// File: rtl/duel_suspect_acc.sv
module duel_suspect_acc
    import duel_pkg::*;
#(
    parameter int unsigned CELLS = 64,
    localparam int unsigned IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int unsigned CNT_W = $clog2(CELLS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  cell_t            val,
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic [IDX_W-1:0] nxt_loc
);

    logic             have_q, have_n;
    score_t           best_q, best_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [IDX_W-1:0] loc_q, loc_n;

    always_comb begin
        have_n = have_q;
        best_n = best_q;
        cnt_n  = cnt_q;
        loc_n  = loc_q;
        if (step && !val.cleared) begin
            if (!have_q || val.score > best_q) begin
                have_n = 1'b1;
                best_n = val.score;
                cnt_n  = CNT_W'(1);
                loc_n  = idx;
            end else if (val.score == best_q) begin
                cnt_n  = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_q <= 1'b0;
            best_q <= '0;
            cnt_q  <= '0;
            loc_q  <= '0;
        end else begin
            have_q <= have_n;
            best_q <= best_n;
            cnt_q  <= cnt_n;
            loc_q  <= loc_n;
        end
    end

    assign nxt_cnt = cnt_n;
    assign nxt_loc = loc_n;

    // R5: the running tally never exceeds the number of cells
    a_r5_tally_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CELLS));

endmodule

// File: rtl/duel_stall_mon.sv
module duel_stall_mon #(
    parameter int unsigned CNT_W = 7,
    parameter int unsigned LIMIT = 3,
    localparam int unsigned RUN_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             eval,
    input  logic [CNT_W-1:0] new_cnt,
    input  logic [CNT_W-1:0] old_cnt,
    input  logic             ack,
    output logic             stall
);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || ack) begin
            run_q <= '0;
        end else if (eval) begin
            if (new_cnt < old_cnt || new_cnt <= CNT_W'(1)) run_q <= '0;
            else if (run_q != RUN_W'(LIMIT))               run_q <= run_q + 1'b1;
        end
    end

    assign stall = (run_q == RUN_W'(LIMIT));

    // R8: an acknowledge removes the request on the next cycle
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        ack |=> !stall);

    // R7: the request can only appear right after a scan ends
    a_r7_stall_after_scan: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(eval));

endmodule

// File: rtl/duel_isolator.sv
module duel_isolator
    import duel_pkg::*;
#(
    parameter int unsigned ROWS        = 8,
    parameter int unsigned COLS        = 8,
    parameter int unsigned STALL_LIMIT = 3,
    localparam int unsigned CELLS = ROWS * COLS,
    localparam int unsigned IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int unsigned CNT_W = $clog2(CELLS + 1),
    localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             duel_valid,
    input  logic [CELLS-1:0] left_map,
    input  logic [CELLS-1:0] right_map,
    input  logic             mismatch,
    input  logic             halve_ack,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] suspect_count,
    output logic             stall,
    output logic             isolated,
    output logic [ROW_W-1:0] fault_row,
    output logic [COL_W-1:0] fault_col
);

    cell_t            grid [CELLS];
    logic [CELLS-1:0] used_q;
    logic             mism_q;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] loc_q;

    cell_t            cur_cell;
    cell_t            nxt_cell;
    logic             last_cell;
    logic             accept;
    logic [CNT_W-1:0] acc_cnt;
    logic [IDX_W-1:0] acc_loc;

    assign cur_cell  = grid[idx_q];
    assign last_cell = busy_q && (idx_q == IDX_W'(CELLS - 1));
    assign accept    = !busy_q && duel_valid;

    duel_cell_rule u_rule (
        .cur      (cur_cell),
        .used     (used_q[idx_q]),
        .mismatch (mism_q),
        .nxt      (nxt_cell)
    );

    duel_suspect_acc #(.CELLS(CELLS)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .step    (busy_q),
        .val     (nxt_cell),
        .idx     (idx_q),
        .nxt_cnt (acc_cnt),
        .nxt_loc (acc_loc)
    );

    duel_stall_mon #(.CNT_W(CNT_W), .LIMIT(STALL_LIMIT)) u_stall (
        .clk     (clk),
        .rst     (rst),
        .eval    (last_cell),
        .new_cnt (acc_cnt),
        .old_cnt (count_q),
        .ack     (halve_ack),
        .stall   (stall)
    );

    // Score storage: one cell is written back per scan cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < CELLS; k++) grid[k] <= '0;
        end else if (busy_q) begin
            grid[idx_q] <= nxt_cell;
        end
    end

    // Scan sequencing and result registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            idx_q   <= '0;
            used_q  <= '0;
            mism_q  <= 1'b0;
            count_q <= CNT_W'(CELLS);
            loc_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                used_q <= left_map | right_map;
                mism_q <= mismatch;
            end else if (busy_q) begin
                if (last_cell) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    count_q <= acc_cnt;
                    loc_q   <= acc_loc;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign busy          = busy_q;
    assign done          = done_q;
    assign suspect_count = count_q;
    assign isolated      = (count_q == CNT_W'(1));
    assign fault_row     = isolated ? ROW_W'(int'(loc_q) / COLS) : '0;
    assign fault_col     = isolated ? COL_W'(int'(loc_q) % COLS) : '0;

    // R2: done lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: a new request during a scan does not end the scan early
    a_r2_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && idx_q != IDX_W'(CELLS - 1)) |=> busy);

    // R5: the published count moves only when a scan ends
    a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(suspect_count));

    // R6: the reported location lies inside the grid
    a_r6_loc_in_grid: assert property (@(posedge clk) disable iff (rst)
        isolated |-> (int'(fault_row) < ROWS && int'(fault_col) < COLS));

    // R7: no halving request once a single suspect is left
    a_r7_no_stall_isolated: assert property (@(posedge clk) disable iff (rst)
        stall |-> !isolated);

endmodule

// File: tb/duel_isolator_bench.sv
module duel_isolator_bench;

    localparam int CELLS = 64;

    typedef struct packed {
        logic [63:0] l;
        logic [63:0] r;
        logic        mm;
        logic [6:0]  cnt;
        logic        iso;
        logic [2:0]  row;
        logic [2:0]  col;
        logic        stl;
        logic        ack;
        logic        poke;
        logic        clr;   // 1: round mainly exercises clearing (R4)
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{64'h00000000FFFFFFFF, 64'h0000FFFF00000000, 1'b1, 7'd48, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h0000FFFFFFFFFFFF, 64'h0,                1'b1, 7'd48, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h0000FFFFFFFFFFFF, 64'h0,                1'b1, 7'd48, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h0000FFFFFFFFFFFF, 64'h0,                1'b1, 7'd48, 1'b0, 3'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{64'hFFFFFFFF00000000, 64'h0,                1'b1, 7'd16, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h000000FF00000000, 64'h0000FB0000000000, 1'b0, 7'd1,  1'b1, 3'd5, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h0000000000000001, 64'h0,                1'b1, 7'd2,  1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h0,                64'h0000040000000000, 1'b1, 7'd1,  1'b1, 3'd5, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0},
        '{64'h0000040000000000, 64'h0,                1'b0, 7'd1,  1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h0000FFFF00000000, 64'h0,                1'b1, 7'd1,  1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        '{64'h0,                64'h0,                1'b0, 7'd1,  1'b1, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        duel_valid = 1'b0;
    logic [63:0] left_map = '0;
    logic [63:0] right_map = '0;
    logic        mismatch = 1'b0;
    logic        halve_ack = 1'b0;
    logic        busy, done, stall, isolated;
    logic [6:0]  suspect_count;
    logic [2:0]  fault_row, fault_col;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    duel_isolator u_duel_isolator (
        .clk           (clk),
        .rst           (rst),
        .duel_valid    (duel_valid),
        .left_map      (left_map),
        .right_map     (right_map),
        .mismatch      (mismatch),
        .halve_ack     (halve_ack),
        .busy          (busy),
        .done          (done),
        .suspect_count (suspect_count),
        .stall         (stall),
        .isolated      (isolated),
        .fault_row     (fault_row),
        .fault_col     (fault_col)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Presents one duel at a negedge and follows the scan to its done pulse.
    task automatic run_duel(input logic [63:0] l, input logic [63:0] r,
                            input logic mm, input logic poke);
        int bad_timing;
        bad_timing = 0;
        left_map   = l;
        right_map  = r;
        mismatch   = mm;
        duel_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            left_map  = '1;
            right_map = '1;
            mismatch  = 1'b1;
        end else begin
            duel_valid = 1'b0;
        end
        for (int c = 1; c <= CELLS; c++) begin
            @(negedge clk);
            if (c == 1) duel_valid = 1'b0;
            if (c < CELLS && (done || !busy)) bad_timing = 1;
            if (c == CELLS && (!done || busy)) bad_timing = 1;
        end
        check("R2", "scan length / done timing", bad_timing, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "suspect_count", int'(suspect_count), CELLS);
        check("R1", "stall", int'(stall), 0);
        check("R1", "isolated", int'(isolated), 0);
        check("R1", "busy/done", int'({busy, done}), 0);
        check("R1", "location", int'({fault_row, fault_col}), 0);

        // Table walk; the fault sits at row 5, column 2 (bit 42).
        for (int i = 0; i < NV; i++) begin
            run_duel(VECS[i].l, VECS[i].r, VECS[i].mm, VECS[i].poke);
            check(VECS[i].clr ? "R4" : "R3", $sformatf("duel %0d count", i),
                  int'(suspect_count), int'(VECS[i].cnt));
            check("R5", $sformatf("duel %0d count", i), int'(suspect_count), int'(VECS[i].cnt));
            check("R6", $sformatf("duel %0d isolated", i), int'(isolated), int'(VECS[i].iso));
            check("R6", $sformatf("duel %0d row", i), int'(fault_row), int'(VECS[i].row));
            check("R6", $sformatf("duel %0d col", i), int'(fault_col), int'(VECS[i].col));
            check("R7", $sformatf("duel %0d stall", i), int'(stall), int'(VECS[i].stl));
            if (VECS[i].ack) begin
                halve_ack = 1'b1;
                @(negedge clk);
                halve_ack = 1'b0;
                check("R8", "stall after halve_ack", int'(stall), 0);
                check("R5", "count untouched by halve_ack", int'(suspect_count), int'(VECS[i].cnt));
            end
        end

        // R5: count holds while idle
        repeat (5) @(negedge clk);
        check("R5", "idle hold", int'(suspect_count), 1);

        // R3 saturation: cells (0,0)=5 and (0,1)=4 both climb to 63 and tie.
        for (int k = 0; k < 70; k++) run_duel(64'h3, 64'h0, 1'b1, 1'b0);
        check("R3", "saturated tie count", int'(suspect_count), 2);
        check("R6", "not isolated on tie", int'(isolated), 0);
        check("R7", "stall on repeated tie", int'(stall), 1);

        // R4 clear everything: no suspects left, counter cleared.
        run_duel('1, 64'h0, 1'b0, 1'b0);
        check("R4", "all cleared count", int'(suspect_count), 0);
        check("R7", "stall cleared at count 0", int'(stall), 0);
        check("R6", "not isolated at 0", int'(isolated), 0);

        // R1 reset again restores the initial view.
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "count after second reset", int'(suspect_count), CELLS);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule